// File: doc/BRIEF.md
# DRAM Refresh Strobe Generator (column-first ordering)

This block keeps a page-mode DRAM module alive by issuing refresh cycles in which the column strobes fall before the row strobes. The memory counts rows internally, so no refresh address is driven. A free-running interval timer adds one refresh to a pending backlog at every expiry. While the backlog is non-zero and the block is idle, it raises a request. The access sequencer answers with a grant. The block then takes over the bus: it drives every row strobe and every column strobe through the refresh ordering, keeps write-enable high, precharges, and hands the bus back.

If the sequencer is slow to grant, expiries accumulate in the backlog. The block then requests again straight after each precharge until the backlog is empty. The backlog saturates at a parameterised maximum. An expiry that arrives at the maximum is lost and sets a sticky overflow flag. Every timing span is a cycle count parameter. The defaults suit a 100 MHz clock: one refresh every 1560 cycles, a lead of 1 cycle, 6 cycles with the row strobes low, and 4 cycles of precharge.

Top module: `cbr_refresh_gen`

## Requirements
- R1: While reset is asserted and directly after it, `req`, `busy` and `overflow` are 0, and every strobe and `we_n` is 1.
- R2: The interval timer expires on the INTERVAL-th clock edge after reset and then every INTERVAL edges. Each expiry adds one to the backlog, and `req` is 1 whenever the block is idle with a non-zero backlog.
- R3: A grant sampled while `req` is 1 makes `busy` go to 1 on the next cycle. `busy` stays at 1 for exactly 1 + LEAD_CYC + RAS_CYC + PRE_CYC cycles.
- R4: Within a refresh, the cycle order is fixed: one cycle with all strobes high, LEAD_CYC cycles with the column strobes low and the row strobes high, RAS_CYC cycles with both low, then PRE_CYC cycles with all strobes high. The column strobes rise on the same edge as the row strobes.
- R5: `we_n` is 1 in every cycle.
- R6: All bits of `ras_n` carry the same value in every cycle, and all bits of `cas_n` carry the same value in every cycle.
- R7: `req` is 0 whenever `busy` is 1. A grant while `req` is 0 is ignored: `busy` stays 0 and the backlog is unchanged.
- R8: Each accepted grant removes one from the backlog. If an expiry and an accepted grant fall in the same cycle, the backlog is unchanged. After precharge, `req` is 1 again while the backlog is non-zero.
- R9: The backlog never exceeds BACKLOG_MAX. An expiry that finds the backlog at BACKLOG_MAX, with no grant accepted in that cycle, sets `overflow`, which stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| grant | input | 1 | Bus grant from the access sequencer |
| req | output | 1 | Refresh wanted |
| busy | output | 1 | Bus held by refresh; the sequencer must not start an access |
| overflow | output | 1 | Sticky: a refresh expiry was lost |
| ras_n | output | N_RAS | Row strobes, active low |
| cas_n | output | N_CAS | Column strobes, active low |
| we_n | output | 1 | Write enable, active low, held high |

## Verification
The assertions assume that `grant` is a synchronous level that changes only between clock edges, and that reset starts every run. They place no restriction on when `grant` is high. For that reason the stimulus drives `grant` held low for long stretches, held high continuously, and as a pseudo-random level. This includes grants while `req` is 0 and while `busy` is 1, which the block must ignore. The held-low stretch runs past BACKLOG_MAX + 1 expiries so that saturation and the sticky flag are reached. A mid-run reset then clears the flag.

// File: rtl/cbr_refresh_gen.sv
module cbr_refresh_gen #(
  parameter int INTERVAL    = 1560,
  parameter int LEAD_CYC    = 1,
  parameter int RAS_CYC     = 6,
  parameter int PRE_CYC     = 4,
  parameter int BACKLOG_MAX = 8,
  parameter int N_RAS       = 4,
  parameter int N_CAS       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant,
  output logic             req,
  output logic             busy,
  output logic             overflow,
  output logic [N_RAS-1:0] ras_n,
  output logic [N_CAS-1:0] cas_n,
  output logic             we_n
);
  localparam int TW = $clog2(INTERVAL);
  localparam int PW = $clog2(BACKLOG_MAX + 1);
  localparam int SPAN = (RAS_CYC > LEAD_CYC ? (RAS_CYC > PRE_CYC ? RAS_CYC : PRE_CYC)
                                            : (LEAD_CYC > PRE_CYC ? LEAD_CYC : PRE_CYC));
  localparam int CW = $clog2(SPAN + 1);

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_LEAD, S_LOW, S_PCHG} st_t;

  st_t          st;
  logic [TW-1:0] tmr;
  logic [PW-1:0] pend;
  logic [CW-1:0] cnt;

  wire tick = (tmr == '0);
  wire take = req && grant;
  wire at_max = (pend == PW'(BACKLOG_MAX));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tmr <= TW'(INTERVAL - 1);
    else        tmr <= tick ? TW'(INTERVAL - 1) : tmr - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend     <= '0;
      overflow <= 1'b0;
    end else begin
      if (tick && !take) begin
        if (at_max) overflow <= 1'b1;
        else        pend <= pend + 1'b1;
      end else if (take && !tick) begin
        pend <= pend - 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (take) st <= S_GAP;
        S_GAP: begin
          st  <= S_LEAD;
          cnt <= CW'(LEAD_CYC - 1);
        end
        S_LEAD:
          if (cnt == '0) begin
            st  <= S_LOW;
            cnt <= CW'(RAS_CYC - 1);
          end else cnt <= cnt - 1'b1;
        S_LOW:
          if (cnt == '0) begin
            st  <= S_PCHG;
            cnt <= CW'(PRE_CYC - 1);
          end else cnt <= cnt - 1'b1;
        S_PCHG:
          if (cnt == '0) st <= S_IDLE;
          else           cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end

  wire cas_low = (st == S_LEAD) || (st == S_LOW);
  wire ras_low = (st == S_LOW);

  assign req   = (st == S_IDLE) && (pend != '0);
  assign busy  = (st != S_IDLE);
  assign ras_n = {N_RAS{~ras_low}};
  assign cas_n = {N_CAS{~cas_low}};
  assign we_n  = 1'b1;

  int lo_cnt, hi_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lo_cnt <= 0;
      hi_cnt <= 0;
    end else begin
      lo_cnt <= ras_n[0] ? 0 : lo_cnt + 1;
      hi_cnt <= !ras_n[0] ? 0 : (hi_cnt < PRE_CYC + 2 ? hi_cnt + 1 : hi_cnt);
    end

  assert_cas_leads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n[0]) |-> (cas_n == '0) && ($past(cas_n) == '0));
  assert_cas_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n[0]) |-> $past(busy) && $past(cas_n) == '1);
  assert_cas_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n[0]) |-> $rose(ras_n[0]));
  assert_ras_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n[0]) |-> lo_cnt == RAS_CYC);
  assert_precharge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> hi_cnt == PRE_CYC);
  assert_lockstep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n == '0 || ras_n == '1) && (cas_n == '0 || cas_n == '1));
  assert_no_req_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req);
  assert_no_overflow_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  assert_backlog_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PW'(BACKLOG_MAX));
endmodule

// File: tb/test_cbr_refresh_gen.sv
module test_cbr_refresh_gen;
  localparam int IV = 40, LD = 1, RW = 6, PC = 4, MX = 8;
  localparam int TOTAL = 1 + LD + RW + PC;

  logic clk = 0, rst_n = 0, grant = 0;
  logic req, busy, overflow, we_n;
  logic [3:0] ras_n, cas_n;

  cbr_refresh_gen #(.INTERVAL(IV), .LEAD_CYC(LD), .RAS_CYC(RW), .PRE_CYC(PC),
                    .BACKLOG_MAX(MX), .N_RAS(4), .N_CAS(4)) i_cbr_refresh_gen (
    .clk(clk), .rst_n(rst_n), .grant(grant), .req(req), .busy(busy),
    .overflow(overflow), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n));

  always #10 clk = ~clk;

  int m_t, m_p, m_pos, m_ovf;
  int ncmp = 0, nbad = 0, mode = 0;
  logic [15:0] lf = 16'hACE1;
  bit done = 0;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m_t = 0; m_p = 0; m_pos = -1; m_ovf = 0;
    end else begin
      bit tk, acc;
      tk  = (m_t == IV - 1);
      m_t = tk ? 0 : m_t + 1;
      acc = (m_pos < 0) && (m_p > 0) && grant;
      if (tk && !acc) begin
        if (m_p == MX) m_ovf = 1; else m_p++;
      end else if (acc && !tk) m_p--;
      if (m_pos >= 0) m_pos = (m_pos == TOTAL - 1) ? -1 : m_pos + 1;
      else if (acc) m_pos = 0;
    end

  task automatic chk(string tag, string what, int act, int exp);
    ncmp++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    bit e_cas, e_ras;
    e_cas = (m_pos >= 1) && (m_pos < 1 + LD + RW);
    e_ras = (m_pos >= 1 + LD) && (m_pos < 1 + LD + RW);
    chk("R2 R8", "req", req, (m_pos < 0 && m_p > 0));
    chk("R3", "busy", busy, m_pos >= 0);
    chk("R4 R6", "cas_n", cas_n, e_cas ? 0 : 15);
    chk("R3 R6", "ras_n", ras_n, e_ras ? 0 : 15);
    chk("R5", "we_n", we_n, 1);
    chk("R7", "req&busy", req & busy, 0);
    chk("R9", "overflow", overflow, m_ovf);
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    case (mode)
      0: grant = 0;
      1: grant = 1;
      default: grant = lf[3] & lf[7];
    endcase
  end

  task automatic reset_checks();
    chk("R1", "req", req, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "overflow", overflow, 0);
    chk("R1", "ras_n", ras_n, 15);
    chk("R1", "cas_n", cas_n, 15);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    reset_checks();
    rst_n = 1;
    @(posedge clk) mode = 1;
    repeat (300) @(posedge clk);
    mode = 0;
    repeat (IV * (MX + 2) + 20) @(posedge clk);
    mode = 1;
    repeat (MX * TOTAL + 2 * IV) @(posedge clk);
    mode = 2;
    repeat (1500) @(posedge clk);
    #2 rst_n = 0;
    @(negedge clk);
    reset_checks();
    @(posedge clk) #2 rst_n = 1;
    repeat (500) @(posedge clk);
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    ncmp++;
    $display("FAIL watchdog run did not finish actual=1 expected=0");
    finish_run();
  end
endmodule